// File: doc/BRIEF.md
# Prefetch Read Data Flush Controller

This block decides when data that was fetched ahead for an in-bound read, and is still waiting in the read data FIFO, has gone stale and must be thrown away. It watches event strobes from the bus side and the out-bound path. These are: an in-bound read finishing, a new in-bound read being accepted, an in-bound write arriving, and an out-bound read or write starting. From these it raises a one-cycle flush pulse toward the FIFO. The FIFO storage and the bus protocol live elsewhere.

Two configuration fields shape the behaviour. A 2-bit discard policy chooses which traffic, besides a timeout, also triggers a discard. A 3-bit timeout code chooses how many clock edges a countdown runs after a read completes before leftover data is dropped. The countdown halts when another in-bound read is accepted. It keeps running through in-bound writes and all out-bound traffic. Some discards happen under every policy: when an accepted in-bound read is not contiguous, and when an in-bound write lands on the prefetched range.

Top module: `prefetch_flush_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `flushPulse` is low, and the countdown is idle: no flush comes until some event strobe is seen.
- R2: Under policies 1, 2 and 3, a `rdDone` strobe loads the countdown. With no other cause, `flushPulse` rises exactly N cycles after the edge that samples `rdDone`. N is 4 shifted left by `cfgTimeout`, so codes 0 through 6 give 4, 8, 16, 32, 64, 128 and 256.
- R3: Timeout code 7 disables the countdown. A `rdDone` under code 7 never leads to a timeout flush.
- R4: An accepted in-bound read (`rdAccept`) stops a running countdown, even on the cycle it would expire. No timeout flush follows until a later `rdDone` reloads it.
- R5: In-bound writes that miss the prefetched range, and out-bound starts that the policy does not name, neither pause nor restart the countdown.
- R6: Under policy 0, `flushPulse` is high on the cycle after the edge that samples `rdDone`. The countdown is not loaded, and no timeout flush follows.
- R7: Under policy 2, `obWrStart` causes a flush on the next cycle and `obRdStart` does not.
- R8: Under policy 3, either `obWrStart` or `obRdStart` causes a flush on the next cycle. Under policies 0 and 1 neither does.
- R9: Under every policy, `rdAccept` with `rdContig` low causes a flush on the next cycle. With `rdContig` high it causes none.
- R10: Under every policy, `wrIn` with `wrHit` high causes a flush on the next cycle. With `wrHit` low it causes none.
- R11: Causes that coincide in one cycle give a single one-cycle pulse. After any flush the countdown is idle until the next `rdDone`.
- R12: A `rdDone` in the same cycle as a flush cause or `rdAccept` still loads the countdown. The coinciding cause still produces its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every event is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfgTimeout | input | 3 | Timeout code; 0..6 select 4<<code edges, 7 disables |
| cfgPolicy | input | 2 | Discard policy: 0 end of read, 1 timeout only, 2 out-bound write or timeout, 3 any out-bound start or timeout |
| rdDone | input | 1 | In-bound read transaction finished on the bus |
| rdAccept | input | 1 | New in-bound read accepted |
| rdContig | input | 1 | Accepted read continues the prefetched address run |
| wrIn | input | 1 | In-bound write received |
| wrHit | input | 1 | The in-bound write overlaps prefetched memory |
| obRdStart | input | 1 | Out-bound read begins |
| obWrStart | input | 1 | Out-bound write begins |
| flushPulse | output | 1 | One-cycle discard request to the read data FIFO |

## Verification
The bench measures the timeout latency for every code. A design off by one edge in its load or its zero test would pulse one cycle early or late, and a wrong shift would miss by a factor of two. It also lands `rdAccept` on the very cycle of expiry, where a design that checks the stop after the decrement would let a stale timeout through. It sends out-bound reads and writes into policies that ignore them, which catches a policy decode that flushes or stalls the count on traffic it should pass over. Finally it stacks `rdDone` onto a cycle with other causes, where a wrong priority would either lose the reload or suppress the pulse.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic [1:0] {
    POL_END_OF_READ  = 2'b00,
    POL_TIMEOUT_ONLY = 2'b01,
    POL_OB_WRITE     = 2'b10,
    POL_OB_ANY       = 2'b11
  } flushPolicy_t;

  // strobes from control to the countdown datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic step;
  } cntCmd_t;

endpackage

// File: rtl/pff_count.sv
module pff_count
  import pff_pkg::*;
#(
  parameter int TO_W       = 3,
  parameter int BASE_SHIFT = 2,
  localparam int CNT_W     = BASE_SHIFT + (1 << TO_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  cntCmd_t         cmd,
  input  logic [TO_W-1:0] cfgTimeout,
  output logic            expiring
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // 2^BASE_SHIFT shifted by the code
  assign loadVal = CNT_W'(1 << BASE_SHIFT) << cfgTimeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cmd.load) begin
      cnt <= loadVal;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.step && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  // zero means idle; one means this edge reaches zero
  assign expiring = (cnt == CNT_W'(1));

endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl
  import pff_pkg::*;
#(
  parameter int TO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TO_W-1:0] cfgTimeout,
  input  logic [1:0]      cfgPolicy,
  input  logic            rdDone,
  input  logic            rdAccept,
  input  logic            rdContig,
  input  logic            wrIn,
  input  logic            wrHit,
  input  logic            obRdStart,
  input  logic            obWrStart,
  input  logic            expiring,
  output cntCmd_t         cmd,
  output logic            flushPulse
);

  flushPolicy_t policy;
  logic timedPolicy;
  logic timeoutOn;
  logic timeoutHit;
  logic policyHit;
  logic alwaysHit;
  logic flushCause;

  assign policy      = flushPolicy_t'(cfgPolicy);
  assign timedPolicy = (policy != POL_END_OF_READ);
  assign timeoutOn   = (cfgTimeout != '1);

  // a read accepted this cycle freezes the count before it can expire
  assign timeoutHit = expiring && !rdAccept && timedPolicy;

  always_comb begin
    unique case (policy)
      POL_END_OF_READ:  policyHit = rdDone;
      POL_TIMEOUT_ONLY: policyHit = 1'b0;
      POL_OB_WRITE:     policyHit = obWrStart;
      POL_OB_ANY:       policyHit = obWrStart || obRdStart;
      default:          policyHit = 1'b0;
    endcase
  end

  assign alwaysHit  = (rdAccept && !rdContig) || (wrIn && wrHit);
  assign flushCause = timeoutHit || policyHit || alwaysHit;

  always_comb begin
    cmd.load  = rdDone && timedPolicy && timeoutOn;
    cmd.clear = !cmd.load && (rdDone || rdAccept || flushCause);
    cmd.step  = !cmd.load && !cmd.clear;
  end

  always_ff @(posedge clk) begin
    if (rst) flushPulse <= 1'b0;
    else     flushPulse <= flushCause;
  end

endmodule

// File: rtl/prefetch_flush_ctrl.sv
module prefetch_flush_ctrl
  import pff_pkg::*;
#(
  parameter int TO_W       = 3,
  parameter int BASE_SHIFT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TO_W-1:0] cfgTimeout,
  input  logic [1:0]      cfgPolicy,
  input  logic            rdDone,
  input  logic            rdAccept,
  input  logic            rdContig,
  input  logic            wrIn,
  input  logic            wrHit,
  input  logic            obRdStart,
  input  logic            obWrStart,
  output logic            flushPulse
);

  cntCmd_t cmd;
  logic    expiring;

  pff_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgTimeout (cfgTimeout),
    .cfgPolicy  (cfgPolicy),
    .rdDone     (rdDone),
    .rdAccept   (rdAccept),
    .rdContig   (rdContig),
    .wrIn       (wrIn),
    .wrHit      (wrHit),
    .obRdStart  (obRdStart),
    .obWrStart  (obWrStart),
    .expiring   (expiring),
    .cmd        (cmd),
    .flushPulse (flushPulse)
  );

  pff_count #(.TO_W(TO_W), .BASE_SHIFT(BASE_SHIFT)) u_count (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .cfgTimeout (cfgTimeout),
    .expiring   (expiring)
  );

endmodule

// File: rtl/pff_checker.sv
module pff_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfgPolicy,
  input logic       rdDone,
  input logic       rdAccept,
  input logic       rdContig,
  input logic       wrIn,
  input logic       wrHit,
  input logic       obRdStart,
  input logic       obWrStart,
  input logic       flushPulse
);

  AST_NONCONTIG_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (rdAccept && !rdContig) |=> flushPulse); // R9

  AST_WRITE_HIT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (wrIn && wrHit) |=> flushPulse); // R10

  AST_END_OF_READ_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cfgPolicy == 2'b00 && rdDone) |=> flushPulse); // R6

  AST_OB_WRITE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cfgPolicy[1] && obWrStart) |=> flushPulse); // R7

  AST_OB_READ_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cfgPolicy == 2'b11 && obRdStart) |=> flushPulse); // R8

endmodule

bind prefetch_flush_ctrl pff_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgPolicy (cfgPolicy),
  .rdDone    (rdDone),
  .rdAccept  (rdAccept),
  .rdContig  (rdContig),
  .wrIn      (wrIn),
  .wrHit     (wrHit),
  .obRdStart (obRdStart),
  .obWrStart (obWrStart),
  .flushPulse(flushPulse)
);

// File: tb/sim_prefetch_flush_ctrl.sv
`timescale 1ns/1ps
module sim_prefetch_flush_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfgTimeout = 3'd0;
  logic [1:0] cfgPolicy  = 2'd1;
  logic rdDone = 0, rdAccept = 0, rdContig = 0, wrIn = 0, wrHit = 0;
  logic obRdStart = 0, obWrStart = 0;
  logic flushPulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int lastFlush = 0;
  int mCnt = 0;          // 0 = idle
  logic mFlush = 1'b0;
  string curReq = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  prefetch_flush_ctrl u0 (
    .clk(clk), .rst(rst), .cfgTimeout(cfgTimeout), .cfgPolicy(cfgPolicy),
    .rdDone(rdDone), .rdAccept(rdAccept), .rdContig(rdContig),
    .wrIn(wrIn), .wrHit(wrHit), .obRdStart(obRdStart), .obWrStart(obWrStart),
    .flushPulse(flushPulse)
  );

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    bit fire, cause, timed;
    cyc = cyc + 1;
    if (rst) begin
      mCnt = 0;
      mFlush = 1'b0;
    end else begin
      timed = (cfgPolicy != 2'd0);
      fire  = timed && (mCnt == 1) && !rdAccept;
      cause = fire
           || (cfgPolicy == 2'd0 && rdDone)
           || (cfgPolicy >= 2'd2 && obWrStart)
           || (cfgPolicy == 2'd3 && obRdStart)
           || (rdAccept && !rdContig)
           || (wrIn && wrHit);
      if (rdDone)
        mCnt = (timed && cfgTimeout != 3'd7) ? (4 << cfgTimeout) : 0;
      else if (cause || rdAccept)
        mCnt = 0;
      else if (mCnt > 0)
        mCnt = mCnt - 1;
      mFlush = cause;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (flushPulse !== mFlush) begin
        errors++;
        $display("FAIL %s cycle %0d flushPulse actual %b expected %b",
                 curReq, cyc, flushPulse, mFlush);
      end
      if (flushPulse === 1'b1) begin
        pulses++;
        lastFlush = cyc;
      end
    end
  end

  task automatic ev(input logic d, a, c, w, h, orr, ow);
    @(negedge clk);
    rdDone = d; rdAccept = a; rdContig = c; wrIn = w; wrHit = h;
    obRdStart = orr; obWrStart = ow;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) ev(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int doneCyc;
    // R1: reset state and quiet start
    curReq = "R1";
    repeat (3) @(negedge clk);
    checkEq("R1 reset", int'(flushPulse), 0);
    rst = 1'b0;
    pulses = 0;
    idle(20);
    checkEq("R1 idle", pulses, 0);

    // R2: latency for every timeout code
    curReq = "R2";
    cfgPolicy = 2'd1;
    for (int t = 0; t < 7; t++) begin
      cfgTimeout = 3'(t);
      ev(1, 0, 0, 0, 0, 0, 0);
      doneCyc = cyc + 1;
      pulses = 0;
      idle((4 << t) + 5);
      checkEq("R2 count", pulses, 1);
      checkEq("R2 latency", lastFlush - doneCyc, 4 << t);
    end

    // R3: code 7 never times out
    curReq = "R3";
    cfgTimeout = 3'd7;
    pulses = 0;
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(300);
    checkEq("R3", pulses, 0);

    // R4: accepted read stops the count, also on the expiry cycle
    curReq = "R4";
    cfgTimeout = 3'd2;
    pulses = 0;
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(5);
    ev(0, 1, 1, 0, 0, 0, 0);
    idle(40);
    checkEq("R4 mid", pulses, 0);
    cfgTimeout = 3'd0;
    ev(1, 0, 0, 0, 0, 0, 0);
    idle(3);
    ev(0, 1, 1, 0, 0, 0, 0);
    idle(20);
    checkEq("R4 edge", pulses, 0);

    // R5: non-hitting writes and unnamed out-bound starts do not stall it
    curReq = "R5";
    cfgTimeout = 3'd1;
    ev(1, 0, 0, 0, 0, 0, 0);
    doneCyc = cyc + 1;
    pulses = 0;
    ev(0, 0, 0, 1, 0, 0, 0);
    ev(0, 0, 0, 0, 0, 1, 0);
    ev(0, 0, 0, 0, 0, 0, 1);
    ev(0, 0, 0, 1, 0, 1, 1);
    idle(10);
    checkEq("R5 count", pulses, 1);
    checkEq("R5 latency", lastFlush - doneCyc, 8);

    // R6: policy 0 flushes at end of read, no timeout afterwards
    curReq = "R6";
    cfgPolicy = 2'd0;
    cfgTimeout = 3'd0;
    ev(1, 0, 0, 0, 0, 0, 0);
    doneCyc = cyc + 1;
    pulses = 0;
    idle(20);
    checkEq("R6 count", pulses, 1);
    checkEq("R6 latency", lastFlush - doneCyc, 0);

    // R7: policy 2
    curReq = "R7";
    cfgPolicy = 2'd2;
    pulses = 0;
    ev(0, 0, 0, 0, 0, 1, 0);
    idle(3);
    checkEq("R7 ob read", pulses, 0);
    ev(0, 0, 0, 0, 0, 0, 1);
    idle(3);
    checkEq("R7 ob write", pulses, 1);

    // R8: policy 3 takes both; policies 0 and 1 take neither
    curReq = "R8";
    cfgPolicy = 2'd3;
    pulses = 0;
    ev(0, 0, 0, 0, 0, 1, 0);
    idle(2);
    ev(0, 0, 0, 0, 0, 0, 1);
    idle(2);
    checkEq("R8 pol3", pulses, 2);
    for (int p = 0; p < 2; p++) begin
      cfgPolicy = 2'(p);
      pulses = 0;
      ev(0, 0, 0, 0, 0, 1, 1);
      idle(2);
      checkEq("R8 pol0/1", pulses, 0);
    end

    // R9 and R10 under every policy
    for (int p = 0; p < 4; p++) begin
      cfgPolicy = 2'(p);
      curReq = "R9";
      pulses = 0;
      ev(0, 1, 1, 0, 0, 0, 0);
      idle(2);
      checkEq("R9 contig", pulses, 0);
      ev(0, 1, 0, 0, 0, 0, 0);
      idle(2);
      checkEq("R9 noncontig", pulses, 1);
      curReq = "R10";
      pulses = 0;
      ev(0, 0, 0, 1, 0, 0, 0);
      idle(2);
      checkEq("R10 miss", pulses, 0);
      ev(0, 0, 0, 1, 1, 0, 0);
      idle(2);
      checkEq("R10 hit", pulses, 1);
    end

    // R11: merged causes, then counter idle after flush
    curReq = "R11";
    cfgPolicy = 2'd3;
    cfgTimeout = 3'd0;
    ev(1, 0, 0, 0, 0, 0, 0);
    pulses = 0;
    ev(0, 1, 0, 1, 1, 1, 1);
    idle(20);
    checkEq("R11 single", pulses, 1);

    // R12: reload wins over a coinciding cause
    curReq = "R12";
    cfgPolicy = 2'd1;
    pulses = 0;
    ev(1, 1, 0, 0, 0, 0, 0);
    doneCyc = cyc + 1;
    idle(10);
    checkEq("R12 count", pulses, 2);
    checkEq("R12 latency", lastFlush - doneCyc, 4);

    // mixed traffic against the model
    curReq = "R11 mixed";
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        cfgPolicy  = 2'($urandom_range(0, 3));
        cfgTimeout = 3'($urandom_range(0, 7));
      end
      ev($urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0,
         $urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0,
         $urandom_range(0, 7) == 0, $urandom_range(0, 24) == 0,
         $urandom_range(0, 24) == 0);
    end
    idle(5);
    summary();
  end

endmodule